// File: doc/BRIEF.md
# Normalizing Barrel Shifter Controller

This block is a left barrel shifter with a registered output. A 4-bit instruction selects where the shift amount comes from, out of four sources:

- a leading-zero priority encoder that measures the data input;
- a shift-value register that samples a 4-bit side port;
- two 4-bit holding registers, called A and B.

Normalize instructions encode the input and shift it in the same cycle, so the most significant 1 lands in the top bit. They can store the count in A or B. They also drive the count out on the side port, unless a force-input control holds that port as input-only.

Load instructions copy the side port into A or B. While a load executes, the data passes through unshifted. The side port is bidirectional, and it is modelled as three signals: a separate input, an output, and an output enable.

Top module: `norm_shift_unit`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears dout, register A, register B and the shift-value register to zero.
- R2: Instruction code 0 (pass), and every code from 9 to 15, gives dout = din one clock later.
- R3: Code 1 shifts din left by the shift-value register, with zero fill. The shift-value register loads sv_in at every clock edge where sv_oe is low.
- R4: Code 2 shifts din left by register A, and code 3 shifts din left by register B.
- R5: Codes 4, 5 and 6 (normalize) shift din left by its count of leading zeros, capped at 15. The result has bit 15 set unless din is zero. A zero din gives a count of 15 and a zero dout.
- R6: Code 4 writes the count into register A and code 5 writes it into register B. Code 6 writes neither. A register that is not written keeps its value.
- R7: sv_oe is high exactly while a normalize code (4, 5 or 6) is applied and sv_force_in is low. While sv_oe is high, sv_out equals the leading-zero count of the present din.
- R8: Code 7 loads sv_in into register A and code 8 loads sv_in into register B. During both codes, dout = din one clock later.
- R9: While sv_oe is high, the shift-value register keeps its value.
- R10: dout and all register updates take effect on the clock edge that follows the instruction. The shift amount used is the one held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 4 | Instruction code |
| din | input | 16 | Data input to the shifter |
| sv_force_in | input | 1 | When high, the side port never drives |
| sv_in | input | 4 | Side port, incoming value |
| sv_out | output | 4 | Side port, outgoing leading-zero count |
| sv_oe | output | 1 | Side port output enable |
| dout | output | 16 | Registered shifter result |

## Verification
The bench builds the block with the defaults: a 16-bit datapath, a 4-bit shift amount and the logarithmic shifter variant. At this width, random data that is right-shifted by a random amount reaches every leading-zero count from 0 to 15. Directed cases cover a zero input and single-bit inputs at both ends of the word. A reference model of the three registers, kept alongside the random stream, checks that stored counts survive across instructions and that side-port samples are suppressed while the port drives.

// File: rtl/nsu_pkg.sv
package nsu_pkg;
   localparam int unsigned OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_PASS   = 4'd0,
      OP_SHF_SV = 4'd1,
      OP_SHF_A  = 4'd2,
      OP_SHF_B  = 4'd3,
      OP_NRM_A  = 4'd4,
      OP_NRM_B  = 4'd5,
      OP_NRM_NS = 4'd6,
      OP_LD_A   = 4'd7,
      OP_LD_B   = 4'd8
   } op_e;

   typedef enum logic [2:0] {
      SRC_ZERO,
      SRC_SVREG,
      SRC_A,
      SRC_B,
      SRC_ENC
   } src_e;

   typedef struct packed {
      src_e src;
      logic wr_a;
      logic wr_b;
      logic norm;
      logic load;
   } ctl_t;
endpackage

// File: rtl/nsu_decode.sv
module nsu_decode
   import nsu_pkg::*;
(
   input  logic [OPC_W-1:0] instr,
   output ctl_t             ctl
);
   always_comb begin
      ctl = '{src: SRC_ZERO, wr_a: 1'b0, wr_b: 1'b0, norm: 1'b0, load: 1'b0};
      case (op_e'(instr))
         OP_SHF_SV: ctl.src = SRC_SVREG;
         OP_SHF_A:  ctl.src = SRC_A;
         OP_SHF_B:  ctl.src = SRC_B;
         OP_NRM_A:  begin ctl.src = SRC_ENC; ctl.norm = 1'b1; ctl.wr_a = 1'b1; end
         OP_NRM_B:  begin ctl.src = SRC_ENC; ctl.norm = 1'b1; ctl.wr_b = 1'b1; end
         OP_NRM_NS: begin ctl.src = SRC_ENC; ctl.norm = 1'b1; end
         OP_LD_A:   begin ctl.load = 1'b1; ctl.wr_a = 1'b1; end
         OP_LD_B:   begin ctl.load = 1'b1; ctl.wr_b = 1'b1; end
         default:   ctl.src = SRC_ZERO;
      endcase
   end
endmodule

// File: rtl/nsu_lzc.sv
module nsu_lzc #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] vec,
   output logic [CNT_W-1:0]  cnt
);
   localparam int unsigned CAP = DATA_W - 1;

   // Scan upward; the highest set bit is found last and wins.
   always_comb begin
      cnt = CNT_W'(CAP);
      for (int i = 0; i < DATA_W; i++) begin
         if (vec[i]) cnt = CNT_W'(CAP - i);
      end
   end
endmodule

// File: rtl/nsu_shl.sv
module nsu_shl #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SHAMT_W = $clog2(DATA_W),
   parameter int unsigned STYLE = 0
) (
   input  logic [DATA_W-1:0]  vec,
   input  logic [SHAMT_W-1:0] amt,
   output logic [DATA_W-1:0]  res
);
   if (STYLE == 0) begin : g_log
      logic [DATA_W-1:0] stg [SHAMT_W+1];
      assign stg[0] = vec;
      for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
         assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
      end
      assign res = stg[SHAMT_W];
   end else begin : g_flat
      assign res = vec << amt;
   end
endmodule

// File: rtl/nsu_regs.sv
module nsu_regs
   import nsu_pkg::*;
#(
   parameter int unsigned SHAMT_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  ctl_t               ctl,
   input  logic               sv_oe,
   input  logic [SHAMT_W-1:0] sv_in,
   input  logic [SHAMT_W-1:0] enc_cnt,
   output logic [SHAMT_W-1:0] reg_a,
   output logic [SHAMT_W-1:0] reg_b,
   output logic [SHAMT_W-1:0] reg_sv
);
   logic [SHAMT_W-1:0] wr_val;
   assign wr_val = ctl.load ? sv_in : enc_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_a  <= '0;
         reg_b  <= '0;
         reg_sv <= '0;
      end else begin
         if (ctl.wr_a) reg_a  <= wr_val;
         if (ctl.wr_b) reg_b  <= wr_val;
         if (!sv_oe)   reg_sv <= sv_in;
      end
   end

   p_sv_hold_r9: assert property (@(posedge clk) disable iff (rst)
      sv_oe |=> $stable(reg_sv));
   p_a_keep_r6: assert property (@(posedge clk) disable iff (rst)
      !ctl.wr_a |=> $stable(reg_a));
   p_b_keep_r6: assert property (@(posedge clk) disable iff (rst)
      !ctl.wr_b |=> $stable(reg_b));
endmodule

// File: rtl/norm_shift_unit.sv
module norm_shift_unit
   import nsu_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SHAMT_W     = $clog2(DATA_W),
   parameter int unsigned SHIFT_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [OPC_W-1:0]   instr,
   input  logic [DATA_W-1:0]  din,
   input  logic               sv_force_in,
   input  logic [SHAMT_W-1:0] sv_in,
   output logic [SHAMT_W-1:0] sv_out,
   output logic               sv_oe,
   output logic [DATA_W-1:0]  dout
);
   if (DATA_W < 2) begin : g_bad_width
      $error("norm_shift_unit: DATA_W must be at least 2");
   end
   if (DATA_W != (1 << SHAMT_W)) begin : g_bad_shamt
      $error("norm_shift_unit: DATA_W must equal 2**SHAMT_W");
   end
   if (SHIFT_STYLE > 1) begin : g_bad_style
      $error("norm_shift_unit: SHIFT_STYLE must be 0 or 1");
   end

   ctl_t               ctl;
   logic [SHAMT_W-1:0] enc_cnt;
   logic [SHAMT_W-1:0] reg_a, reg_b, reg_sv;
   logic [SHAMT_W-1:0] amt;
   logic [DATA_W-1:0]  shifted;

   nsu_decode u_dec (.instr(instr), .ctl(ctl));

   nsu_lzc #(.DATA_W(DATA_W), .CNT_W(SHAMT_W)) u_lzc (
      .vec(din), .cnt(enc_cnt));

   assign sv_oe  = ctl.norm & ~sv_force_in;
   assign sv_out = enc_cnt;

   nsu_regs #(.SHAMT_W(SHAMT_W)) u_regs (
      .clk(clk), .rst(rst), .ctl(ctl), .sv_oe(sv_oe), .sv_in(sv_in),
      .enc_cnt(enc_cnt), .reg_a(reg_a), .reg_b(reg_b), .reg_sv(reg_sv));

   always_comb begin
      case (ctl.src)
         SRC_SVREG: amt = reg_sv;
         SRC_A:     amt = reg_a;
         SRC_B:     amt = reg_b;
         SRC_ENC:   amt = enc_cnt;
         default:   amt = '0;
      endcase
   end

   nsu_shl #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .STYLE(SHIFT_STYLE)) u_shl (
      .vec(din), .amt(amt), .res(shifted));

   always_ff @(posedge clk) begin
      if (rst) dout <= '0;
      else     dout <= shifted;
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (dout == '0));
   p_force_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      sv_force_in |-> !sv_oe);
   p_norm_out_r5: assert property (@(posedge clk) disable iff (rst)
      sv_oe |=> (dout == ($past(din) << $past(sv_out))));
   p_norm_msb_r5: assert property (@(posedge clk) disable iff (rst)
      (ctl.norm && (|din)) |=> dout[DATA_W-1]);
   p_load_pass_r8: assert property (@(posedge clk) disable iff (rst)
      ctl.load |=> (dout == $past(din)));
endmodule

// File: tb/norm_shift_unit_tb.sv
`timescale 1ns/1ps
module norm_shift_unit_tb_top;
   localparam int DW = 16;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [3:0]    instr = '0;
   logic [DW-1:0] din = '0;
   logic          force_in = 1'b0;
   logic [SW-1:0] sv_in = '0;
   logic [SW-1:0] sv_out;
   logic          sv_oe;
   logic [DW-1:0] dout;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   logic [SW-1:0] m_a = '0, m_b = '0, m_sv = '0;

   always #10 clk = ~clk;

   norm_shift_unit dut_i (
      .clk(clk), .rst(rst), .instr(instr), .din(din), .sv_force_in(force_in),
      .sv_in(sv_in), .sv_out(sv_out), .sv_oe(sv_oe), .dout(dout));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lz(logic [DW-1:0] d);
      int n = 0;
      for (int i = DW - 1; i >= 0; i--) begin
         if (d[i]) break;
         n++;
      end
      return (n > DW - 1) ? DW - 1 : n;
   endfunction

   // Called at a falling edge; checks side port, then dout after the edge.
   task automatic step(int op, logic [DW-1:0] d, bit f, logic [SW-1:0] s,
                       string note = "");
      bit norm;
      bit e_oe;
      int amt;
      string tag;
      logic [DW-1:0] exp;
      instr = op[3:0]; din = d; force_in = f; sv_in = s;
      #1;
      norm = (op >= 4 && op <= 6);
      e_oe = norm && !f;
      chk("R7 sv_oe", {31'd0, sv_oe}, {31'd0, e_oe});
      if (e_oe) chk("R7 sv_out", {28'd0, sv_out}, lz(d));
      case (op)
         1: begin amt = m_sv; tag = "R3 shift by sv reg"; end
         2: begin amt = m_a; tag = "R4 shift by A"; end
         3: begin amt = m_b; tag = "R4 shift by B"; end
         4, 5, 6: begin amt = lz(d); tag = "R5 normalize"; end
         7, 8: begin amt = 0; tag = "R8 load passes data"; end
         default: begin amt = 0; tag = "R2 pass"; end
      endcase
      exp = d << amt;
      if (op == 4) m_a = SW'(lz(d));
      if (op == 5) m_b = SW'(lz(d));
      if (op == 7) m_a = s;
      if (op == 8) m_b = s;
      if (!e_oe) m_sv = s;
      @(posedge clk);
      @(negedge clk);
      chk({tag, note, " R10"}, {16'd0, dout}, {16'd0, exp});
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R10 actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1 dout after reset", {16'd0, dout}, 32'd0);
      step(2, 16'hABCD, 0, 4'd0, " R1 A cleared");
      step(3, 16'h1234, 0, 4'd0, " R1 B cleared");
      step(1, 16'h0F0F, 0, 4'd5, " R1 sv cleared");
      step(1, 16'h0F0F, 0, 4'd0, " sv loaded 5");
      step(4, 16'h0000, 0, 4'd3, " zero input");
      step(2, 16'h0001, 0, 4'd0, " R6 A holds 15");
      step(4, 16'h8000, 0, 4'd0, " msb set");
      step(5, 16'h0001, 0, 4'd0, " lsb only");
      step(3, 16'h0001, 0, 4'd0, " R6 B holds 15");
      step(7, 16'h0003, 0, 4'd7);
      step(2, 16'h0003, 0, 4'd0, " A loaded 7");
      step(6, 16'h0100, 0, 4'd2);
      step(2, 16'h0005, 0, 4'd0, " R6 A kept after no-store");
      step(8, 16'h00FF, 1, 4'd4);
      step(3, 16'h00FF, 0, 4'd0, " B loaded 4");
      step(1, 16'h0001, 0, 4'd6);
      step(5, 16'h0040, 0, 4'd9);
      step(1, 16'h0001, 0, 4'd9, " R9 sv kept while driving");
      step(6, 16'h0040, 1, 4'd11, " forced input");
      step(1, 16'h0001, 0, 4'd11, " R9 sv captured when forced");
      step(15, 16'hBEEF, 0, 4'd0);
      step(9, 16'h1357, 0, 4'd0);
      for (int k = 0; k < 600; k++) begin
         int op;
         logic [DW-1:0] d;
         op = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 9);
         d = DW'($urandom) >> ($urandom % 17);
         step(op, d, ($urandom % 4) == 0, SW'($urandom));
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule